// File: doc/BRIEF.md
# ADC Sample/Hold Timing Sequencer

This block times single-channel sequential conversions for a sampling ADC. A start request from any of three sources (a PWM event, a software strobe or an external pin) launches a sequence of one or more conversions on the selected channel. For each conversion the block drives a sample/hold pulse whose width is programmable. It captures the converter's data word on the falling edge of that pulse. After a fixed conversion latency it writes the word into a result register with a one-cycle strobe. A few cycles after every result write it sets a sticky interrupt flag.

The sequencer runs on a clock at twice the ADC conversion clock. All timing below is given in these system cycles, and one ADC clock equals two system cycles. The analog converter is modelled by the `adc_din` data input. A start request that arrives while a sequence is running is held as a single pending request and is served once the running sequence has finished.

Top module: `adc_sh_seq`

## Requirements
- R1: A one-cycle high level on `trig_pwm`, `trig_sw` or `trig_ext`, seen on a clock edge while the sequencer is idle, starts a sequence on that edge (edge E0).
- R2: Each sample/hold pulse stays high for 2*(1+A) cycles, where A is `acq_sel` (0 to 15) captured at E0.
- R3: The first sample/hold pulse rises 5 cycles (2.5 ADC clocks) after E0.
- R4: On the edge where `sh_pulse` falls, `adc_din` is captured. Eight cycles later (4 ADC clocks), `res_stb` is high for one cycle and `res_data` holds the captured word until the next result.
- R5: A sequence performs `burst_m1`+1 conversions, with `burst_m1` captured at E0. Pulses rise, and results arrive, every 2*(2+A) cycles.
- R6: `irq_flag` rises exactly 3 cycles after the edge that raises `res_stb`. It stays high until `irq_clr` is sampled high. If a set and a clear fall on the same edge, the set wins.
- R7: A start request seen while a sequence runs becomes pending and starts the next sequence on the edge after the last result of the running one. Several requests during one sequence yield only one further sequence, and none restarts the running sequence.
- R8: After reset, `sh_pulse`, `res_stb`, `res_data` and `irq_flag` are all zero.
- R9: `sh_chan` shows `chan_sel` as captured at E0. Later changes of `chan_sel` have no effect until the next sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pwm | input | 1 | Start request from PWM event |
| trig_sw | input | 1 | Start request from software |
| trig_ext | input | 1 | Start request from external pin |
| acq_sel | input | 4 | Acquisition setting A, 0 to 15 |
| burst_m1 | input | 4 | Conversions per sequence minus one |
| chan_sel | input | 4 | Channel to convert |
| adc_din | input | 12 | Converter data word (stub) |
| irq_clr | input | 1 | Clears the interrupt flag |
| sh_pulse | output | 1 | Sample/hold pulse |
| sh_chan | output | 4 | Channel of the running sequence |
| res_stb | output | 1 | Result write strobe |
| res_data | output | 12 | Result register |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The interrupt flag can be set by a lagging result and cleared by software on the same edge. The bench holds `irq_clr` high in exactly the cycle before the set edge and expects the flag to read high afterwards, then clears it on its own. In a second collision, new start requests arrive while a sequence is still draining its conversion pipeline. The bench expects exactly one follow-on sequence, starting on the edge after the last result and carrying the channel selected at that time. A scoreboard fed by the stimulus tasks predicts every pulse edge, pulse width, result cycle and result word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_HOLD,
    ST_GAP,
    ST_DRAIN
  } seq_st_t;
endpackage

// File: rtl/adc_trig_arb.sv
module adc_trig_arb (
  input  logic clk,
  input  logic rst,
  input  logic trig_pwm,
  input  logic trig_sw,
  input  logic trig_ext,
  input  logic seq_idle,
  output logic go,
  output logic pend_q
);
  logic trig_any;

  assign trig_any = trig_pwm | trig_sw | trig_ext;
  assign go       = trig_any | pend_q;

  // One pending slot: it is consumed as soon as the sequencer is idle.
  always_ff @(posedge clk) begin
    if (rst)           pend_q <= 1'b0;
    else if (seq_idle) pend_q <= 1'b0;
    else if (trig_any) pend_q <= 1'b1;
  end

  // R7: a request seen while busy is held for later.
  a_r7_busy_latch: assert property (@(posedge clk) disable iff (rst)
    (!seq_idle && trig_any) |=> pend_q);
endmodule

// File: rtl/adc_sh_timer.sv
module adc_sh_timer
  import adc_seq_pkg::*;
#(
  parameter int ACQ_W    = 4,
  parameter int BURST_W  = 4,
  parameter int CH_W     = 4,
  parameter int RATIO    = 2,
  parameter int DLY_HALF = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [ACQ_W-1:0]   acq_sel,
  input  logic [BURST_W-1:0] burst_m1,
  input  logic [CH_W-1:0]    chan_sel,
  input  logic               pipe_tail_only,
  output logic               seq_idle,
  output logic               samp_take,
  output logic               sh_o,
  output logic [CH_W-1:0]    sh_chan
);
  localparam int MAX_HOLD = RATIO * (2 ** ACQ_W);
  localparam int TMR_W    = $clog2(MAX_HOLD + DLY_HALF + 1);
  localparam int HC_W     = $clog2(MAX_HOLD + 2);

  seq_st_t            st;
  logic [TMR_W-1:0]   tmr;
  logic [ACQ_W-1:0]   acq_q;
  logic [BURST_W-1:0] rem;
  logic [TMR_W-1:0]   hold_ld;
  logic               tmr_done;

  assign hold_ld   = TMR_W'((int'(acq_q) + 1) * RATIO - 1);
  assign tmr_done  = (tmr == '0);
  assign seq_idle  = (st == ST_IDLE);
  assign samp_take = (st == ST_HOLD) && tmr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      tmr     <= '0;
      acq_q   <= '0;
      rem     <= '0;
      sh_o    <= 1'b0;
      sh_chan <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (go) begin
            st      <= ST_DELAY;
            tmr     <= TMR_W'(DLY_HALF - 1);
            acq_q   <= acq_sel;
            rem     <= burst_m1;
            sh_chan <= chan_sel;
          end
        end
        ST_DELAY, ST_GAP: begin
          if (tmr_done) begin
            st   <= ST_HOLD;
            sh_o <= 1'b1;
            tmr  <= hold_ld;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_HOLD: begin
          if (tmr_done) begin
            sh_o <= 1'b0;
            if (rem != '0) begin
              rem <= rem - 1'b1;
              st  <= ST_GAP;
              tmr <= TMR_W'(RATIO - 1);
            end else begin
              st <= ST_DRAIN;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_DRAIN: begin
          if (pipe_tail_only) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Checker: independent count of the cycles the pulse has been high.
  logic [HC_W-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)       hi_cnt <= '0;
    else if (sh_o) hi_cnt <= hi_cnt + 1'b1;
    else           hi_cnt <= '0;
  end

  // R2: pulse width equals RATIO*(1+A).
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(sh_o) |-> (int'(hi_cnt) == RATIO * (int'(acq_q) + 1)));

  // R8: no sample/hold pulse while the sequencer is idle.
  a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
    seq_idle |-> !sh_o);
endmodule

// File: rtl/adc_conv_pipe.sv
module adc_conv_pipe #(
  parameter int DW  = 12,
  parameter int LAT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_take,
  input  logic [DW-1:0] din,
  output logic          pipe_tail_only,
  output logic          res_stb,
  output logic [DW-1:0] res_data
);
  logic [LAT-1:0] vld;
  logic [DW-1:0]  dat [LAT];

  always_ff @(posedge clk) begin
    if (rst) vld[0] <= 1'b0;
    else     vld[0] <= samp_take;
    if (samp_take) dat[0] <= din;
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vld[i] <= 1'b0;
      else     vld[i] <= vld[i-1];
      dat[i] <= dat[i-1];
    end
  end

  assign pipe_tail_only = vld[LAT-1] && !(|vld[LAT-2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_stb  <= 1'b0;
      res_data <= '0;
    end else begin
      res_stb <= vld[LAT-1];
      if (vld[LAT-1]) res_data <= dat[LAT-1];
    end
  end

  // R5: results never arrive on adjacent cycles.
  a_r5_result_gap: assert property (@(posedge clk) disable iff (rst)
    res_stb |=> !res_stb);
  // R4: the result register only changes with a strobe.
  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
    !res_stb |-> $stable(res_data));
endmodule

// File: rtl/adc_irq_lag.sv
module adc_irq_lag #(
  parameter int LAG = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic res_in,
  input  logic irq_clr,
  output logic irq_flag
);
  localparam int SC_W = $clog2(LAG + 2);

  logic [LAG-2:0] dly;

  always_ff @(posedge clk) begin
    if (rst) dly[0] <= 1'b0;
    else     dly[0] <= res_in;
  end

  for (genvar i = 1; i < LAG - 1; i++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) dly[i] <= 1'b0;
      else     dly[i] <= dly[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              irq_flag <= 1'b0;
    else if (dly[LAG-2])  irq_flag <= 1'b1;
    else if (irq_clr)     irq_flag <= 1'b0;
  end

  // Checker: cycles since the last result strobe, saturating.
  logic [SC_W-1:0] since_res;
  always_ff @(posedge clk) begin
    if (rst)                            since_res <= SC_W'(LAG + 1);
    else if (res_in)                    since_res <= SC_W'(1);
    else if (since_res != SC_W'(LAG+1)) since_res <= since_res + 1'b1;
  end

  // R6: the flag rises exactly LAG cycles after the result strobe edge.
  a_r6_irq_lag: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> (int'(since_res) == LAG));
  // R6: the flag holds until a clear is seen.
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag);
endmodule

// File: rtl/adc_sh_seq.sv
module adc_sh_seq #(
  parameter int ACQ_W    = 4,
  parameter int BURST_W  = 4,
  parameter int CH_W     = 4,
  parameter int DW       = 12,
  parameter int RATIO    = 2,
  parameter int DLY_HALF = 5,
  parameter int CONV_ADC = 4,
  parameter int IRQ_LAG  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_pwm,
  input  logic               trig_sw,
  input  logic               trig_ext,
  input  logic [ACQ_W-1:0]   acq_sel,
  input  logic [BURST_W-1:0] burst_m1,
  input  logic [CH_W-1:0]    chan_sel,
  input  logic [DW-1:0]      adc_din,
  input  logic               irq_clr,
  output logic               sh_pulse,
  output logic [CH_W-1:0]    sh_chan,
  output logic               res_stb,
  output logic [DW-1:0]      res_data,
  output logic               irq_flag
);
  localparam int LAT = CONV_ADC * RATIO;

  logic go, pend_q, seq_idle, samp_take, tail_only;

  adc_trig_arb u_arb (
    .clk(clk), .rst(rst),
    .trig_pwm(trig_pwm), .trig_sw(trig_sw), .trig_ext(trig_ext),
    .seq_idle(seq_idle), .go(go), .pend_q(pend_q)
  );

  adc_sh_timer #(
    .ACQ_W(ACQ_W), .BURST_W(BURST_W), .CH_W(CH_W),
    .RATIO(RATIO), .DLY_HALF(DLY_HALF)
  ) u_tmr (
    .clk(clk), .rst(rst), .go(go),
    .acq_sel(acq_sel), .burst_m1(burst_m1), .chan_sel(chan_sel),
    .pipe_tail_only(tail_only), .seq_idle(seq_idle),
    .samp_take(samp_take), .sh_o(sh_pulse), .sh_chan(sh_chan)
  );

  adc_conv_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
    .clk(clk), .rst(rst), .samp_take(samp_take), .din(adc_din),
    .pipe_tail_only(tail_only), .res_stb(res_stb), .res_data(res_data)
  );

  adc_irq_lag #(.LAG(IRQ_LAG)) u_irq (
    .clk(clk), .rst(rst), .res_in(res_stb),
    .irq_clr(irq_clr), .irq_flag(irq_flag)
  );

  // R7: a pending request never coexists with an idle sequencer past one cycle.
  a_r7_pend_served: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && pend_q) |=> !seq_idle);
endmodule

// File: tb/adc_sh_seq_test.sv
module adc_sh_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_pwm = 1'b0, trig_sw = 1'b0, trig_ext = 1'b0;
  logic [3:0]  acq_sel = '0, burst_m1 = '0, chan_sel = '0;
  logic [11:0] adc_din = '0;
  logic        irq_clr = 1'b0;
  logic        sh_pulse, res_stb, irq_flag;
  logic [3:0]  sh_chan;
  logic [11:0] res_data;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int q_rise[$], q_w[$], q_ch[$], q_rt[$], q_rd[$];
  int rise_at = 0, cur_w = 0;
  logic sh_prev = 1'b0;

  adc_sh_seq uut (
    .clk(clk), .rst(rst), .trig_pwm(trig_pwm), .trig_sw(trig_sw),
    .trig_ext(trig_ext), .acq_sel(acq_sel), .burst_m1(burst_m1),
    .chan_sel(chan_sel), .adc_din(adc_din), .irq_clr(irq_clr),
    .sh_pulse(sh_pulse), .sh_chan(sh_chan), .res_stb(res_stb),
    .res_data(res_data), .irq_flag(irq_flag)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) adc_din <= 12'((cyc ^ 'h5A5) & 'hFFF);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Returns the cycle index m in which the request was high; E0 = m+1.
  task automatic pulse(input int src, output int m);
    @(negedge clk);
    case (src)
      0: trig_pwm = 1'b1;
      1: trig_sw  = 1'b1;
      default: trig_ext = 1'b1;
    endcase
    m = cyc;
    @(negedge clk);
    trig_pwm = 1'b0; trig_sw = 1'b0; trig_ext = 1'b0;
  endtask

  // Scoreboard driver: pushes predicted pulses and results of one sequence.
  task automatic plan_seq(input int e0, input int a, input int nb, input int ch,
                          output int rlast);
    int w = 2 * (1 + a);
    int p = 2 * (2 + a);
    for (int k = 0; k < nb; k++) begin
      int rise = e0 + 5 + k * p;
      int f = rise + w;
      q_rise.push_back(rise); q_w.push_back(w); q_ch.push_back(ch);
      q_rt.push_back(f + 8);
      q_rd.push_back(((f - 1) ^ 'h5A5) & 'hFFF);
      rlast = f + 8;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq_flag == 1'b0, "R6 clear", int'(irq_flag), 0);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (sh_pulse && !sh_prev) begin
        rise_at = cyc;
        if (q_rise.size() == 0) chk(1'b0, "R7 unexpected pulse", cyc, -1);
        else begin
          int er, ec;
          er = q_rise.pop_front(); cur_w = q_w.pop_front(); ec = q_ch.pop_front();
          chk(cyc == er, "R3 R5 pulse rise", cyc, er);
          chk(int'(sh_chan) == ec, "R9 channel", int'(sh_chan), ec);
        end
      end
      if (!sh_pulse && sh_prev)
        chk(cyc - rise_at == cur_w, "R2 pulse width", cyc - rise_at, cur_w);
      if (res_stb) begin
        if (q_rt.size() == 0) chk(1'b0, "R7 unexpected result", cyc, -1);
        else begin
          int et, ed;
          et = q_rt.pop_front(); ed = q_rd.pop_front();
          chk(cyc == et, "R4 R5 result cycle", cyc, et);
          chk(int'(res_data) == ed, "R4 result data", int'(res_data), ed);
        end
      end
    end
    sh_prev = sh_pulse;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int m, r1, r2, e0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sh_pulse == 1'b0, "R8 reset sh", int'(sh_pulse), 0);
    chk(res_stb == 1'b0, "R8 reset stb", int'(res_stb), 0);
    chk(res_data == '0, "R8 reset data", int'(res_data), 0);
    chk(irq_flag == 1'b0, "R8 reset irq", int'(irq_flag), 0);

    // R1 R6: PWM source, shortest window, one conversion, interrupt lag
    acq_sel = 4'd0; burst_m1 = 4'd0; chan_sel = 4'd3;
    pulse(0, m); plan_seq(m + 1, 0, 1, 3, r1);
    wait_cyc(r1 + 2);
    chk(irq_flag == 1'b0, "R6 not yet set", int'(irq_flag), 0);
    wait_cyc(r1 + 3);
    chk(irq_flag == 1'b1, "R6 set after lag", int'(irq_flag), 1);
    wait_cyc(r1 + 20);
    chk(irq_flag == 1'b1, "R6 sticky", int'(irq_flag), 1);
    clear_irq();

    // R1 R5: software source, widest window, three conversions
    acq_sel = 4'd15; burst_m1 = 4'd2; chan_sel = 4'd1;
    pulse(1, m); plan_seq(m + 1, 15, 3, 1, r1);
    wait_cyc(r1 + 10);

    // R1 R5: external source, four back-to-back pipelined conversions
    acq_sel = 4'd0; burst_m1 = 4'd3; chan_sel = 4'd2;
    pulse(2, m); plan_seq(m + 1, 0, 4, 2, r1);
    wait_cyc(r1 + 10);

    acq_sel = 4'd3; burst_m1 = 4'd1; chan_sel = 4'd7;
    pulse(2, m); plan_seq(m + 1, 3, 2, 7, r1);
    wait_cyc(r1 + 10);
    clear_irq();

    // R6 collision: clear and set on the same edge, set wins
    acq_sel = 4'd1; burst_m1 = 4'd0; chan_sel = 4'd4;
    pulse(0, m); plan_seq(m + 1, 1, 1, 4, r1);
    wait_cyc(r1 + 2);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq_flag == 1'b1, "R6 set beats clear", int'(irq_flag), 1);
    @(negedge clk);
    chk(irq_flag == 1'b1, "R6 set beats clear hold", int'(irq_flag), 1);
    clear_irq();

    // R7 R9: two requests during a running sequence, channel changed mid-run
    acq_sel = 4'd2; burst_m1 = 4'd1; chan_sel = 4'd5;
    pulse(1, m); e0 = m + 1; plan_seq(e0, 2, 2, 5, r1);
    wait_cyc(e0 + 6);
    chan_sel = 4'd9;
    pulse(0, m);
    wait_cyc(e0 + 12);
    pulse(2, m);
    plan_seq(r1 + 1, 2, 2, 9, r2);
    wait_cyc(r2 + 60);
    chk(q_rise.size() == 0, "R7 single follow-on pulses", q_rise.size(), 0);
    chk(q_rt.size() == 0, "R7 single follow-on results", q_rt.size(), 0);
    chk(sh_pulse == 1'b0, "R7 idle after follow-on", int'(sh_pulse), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule